// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block holds the interrupt mask of a serial peripheral and folds the peripheral's live status vector into a single interrupt request. Software never writes the mask directly. It writes a one-hot or multi-bit pattern to a set port to enable sources, or to a clear port to disable them. Bits written as zero leave the mask untouched. Two agents can therefore change different sources without a read-modify-write race.

The mask is read back on a dedicated output. The interrupt line is raised while at least one source is both active in the status vector and enabled in the mask. The set port, the clear port, the mask and the status vector all share one bit layout. Only twelve positions are implemented. Every other position is tied to zero and cannot be enabled.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A cycle with `set_we` high sets every mask bit whose `set_data` bit is 1; the new mask is visible on `mask_rd` after that clock edge.
- R2: A cycle with `clr_we` high clears every mask bit whose `clr_data` bit is 1, after that clock edge.
- R3: Data bits written as 0 on either port, and cycles with no write strobe, leave the corresponding mask bits unchanged.
- R4: While `rst_n` is low the mask is all zeros and `irq` is low.
- R5: Reserved positions (every bit outside R6's list) ignore writes, read back 0 on `mask_rd`, and never raise `irq`.
- R6: The implemented source positions are bits 0, 1, 3, 4, 5, 6, 7, 9, 11, 12, 30 and 31. Setting all bits gives `mask_rd` = 0xC0001AFB.
- R7: `irq` is high in the same cycle that any status bit is 1 at a position whose mask bit is 1.
- R8: When set and clear strobes fall in the same cycle, a bit that is 1 in both data words ends cleared. A bit that is 1 in only one of them follows R1 or R2.
- R9: An active status bit at a position whose mask bit is 0 does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_we | input | 1 | Write strobe of the set (enable) register |
| set_data | input | 32 | Bits to enable; 1 sets, 0 no effect |
| clr_we | input | 1 | Write strobe of the clear (disable) register |
| clr_data | input | 32 | Bits to disable; 1 clears, 0 no effect |
| status | input | 32 | Live status vector, same layout as the mask |
| mask_rd | output | 32 | Current mask readback |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a collision: both strobes in one cycle, with overlapping and disjoint bits, on top of a mask that already holds set bits. The stimulus first sets a mixed pattern. It then issues simultaneous set and clear words that share some bits, differ in others, and touch reserved positions. A walk over all 32 positions sets and clears each bit alone with every status bit asserted. This shows which positions can raise the interrupt and which are inert.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

   localparam int unsigned IRQM_W = 32;

   // Source positions. The enable, disable, mask and status words share them.
   localparam int unsigned SRC_RX_READY   = 0;
   localparam int unsigned SRC_TX_READY   = 1;
   localparam int unsigned SRC_RX_END     = 3;
   localparam int unsigned SRC_TX_END     = 4;
   localparam int unsigned SRC_OVERRUN    = 5;
   localparam int unsigned SRC_FRAMING    = 6;
   localparam int unsigned SRC_PARITY     = 7;
   localparam int unsigned SRC_TX_IDLE    = 9;
   localparam int unsigned SRC_TXBUF_EMPTY= 11;
   localparam int unsigned SRC_RXBUF_FULL = 12;
   localparam int unsigned SRC_DBG_WRITE  = 30;
   localparam int unsigned SRC_DBG_READ   = 31;

   function automatic logic [IRQM_W-1:0] src_bit(input int unsigned pos);
      logic [IRQM_W-1:0] v;
      v = '0;
      v[pos] = 1'b1;
      return v;
   endfunction

   localparam logic [IRQM_W-1:0] IRQM_SRC_MAP =
        src_bit(SRC_RX_READY)    | src_bit(SRC_TX_READY)
      | src_bit(SRC_RX_END)      | src_bit(SRC_TX_END)
      | src_bit(SRC_OVERRUN)     | src_bit(SRC_FRAMING)
      | src_bit(SRC_PARITY)      | src_bit(SRC_TX_IDLE)
      | src_bit(SRC_TXBUF_EMPTY) | src_bit(SRC_RXBUF_FULL)
      | src_bit(SRC_DBG_WRITE)   | src_bit(SRC_DBG_READ);

   typedef struct packed {
      logic set;
      logic clr;
   } irqm_cmd_t;

endpackage

// File: rtl/irqm_wr_qual.sv
module irqm_wr_qual #(
   parameter int unsigned          DATA_W  = 32,
   parameter logic [DATA_W-1:0]    SRC_MAP = '1
) (
   input  logic                     set_we,
   input  logic [DATA_W-1:0]        set_data,
   input  logic                     clr_we,
   input  logic [DATA_W-1:0]        clr_data,
   output irqm_pkg::irqm_cmd_t      cmd_o [DATA_W]
);
   // Per-bit command. Clear wins over set on the same bit (R8).
   // Reserved positions never receive a command (R5).
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (SRC_MAP[i]) begin : g_live
         always_comb begin
            cmd_o[i].clr = clr_we & clr_data[i];
            cmd_o[i].set = set_we & set_data[i] & ~(clr_we & clr_data[i]);
         end
      end else begin : g_rsvd
         always_comb begin
            cmd_o[i].clr = 1'b0;
            cmd_o[i].set = 1'b0;
         end
      end
   end
endmodule

// File: rtl/irqm_mask_cell.sv
module irqm_mask_cell (
   input  logic                 clk,
   input  logic                 rst_n,
   input  irqm_pkg::irqm_cmd_t  cmd_i,
   output logic                 q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_o <= 1'b0;
      else if (cmd_i.clr)  q_o <= 1'b0;
      else if (cmd_i.set)  q_o <= 1'b1;
   end
endmodule

// File: rtl/irqm_reduce.sv
module irqm_reduce #(
   parameter int unsigned DATA_W  = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              irq_o
);
   logic [DATA_W-1:0] hit;
   logic              any_hit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_and
      assign hit[i] = status_i[i] & mask_i[i];
   end
   assign any_hit = |hit;

   if (IRQ_REG) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= any_hit;
      end
   end else begin : g_comb
      assign irq_o = any_hit;
   end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
   parameter int unsigned       DATA_W  = irqm_pkg::IRQM_W,
   parameter logic [DATA_W-1:0] SRC_MAP = irqm_pkg::IRQM_SRC_MAP,
   parameter bit                IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic [DATA_W-1:0] set_data,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] clr_data,
   input  logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] mask_rd,
   output logic              irq
);
   localparam int unsigned N_SRC = $countones(SRC_MAP);

   if (DATA_W == 0 || DATA_W > 64) begin : g_chk_w
      $error("irq_mask_ctrl: DATA_W must be 1..64");
   end
   if (N_SRC == 0) begin : g_chk_map
      $error("irq_mask_ctrl: SRC_MAP selects no source");
   end

   irqm_pkg::irqm_cmd_t cmd [DATA_W];

   irqm_wr_qual #(.DATA_W(DATA_W), .SRC_MAP(SRC_MAP)) u_qual (
      .set_we  (set_we),
      .set_data(set_data),
      .clr_we  (clr_we),
      .clr_data(clr_data),
      .cmd_o   (cmd)
   );

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (SRC_MAP[i]) begin : g_cell
         irqm_mask_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .cmd_i(cmd[i]),
            .q_o  (mask_rd[i])
         );
      end else begin : g_tie
         assign mask_rd[i] = 1'b0;
      end
   end

   irqm_reduce #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_reduce (
      .clk     (clk),
      .rst_n   (rst_n),
      .status_i(status),
      .mask_i  (mask_rd),
      .irq_o   (irq)
   );

   // Assertions next to the mask state
   p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=>
         ((mask_rd & $past(set_data) & SRC_MAP) == ($past(set_data) & SRC_MAP)));

   p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((mask_rd & $past(clr_data)) == '0));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask_rd));

   p_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_rd & ~SRC_MAP) == '0);

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_rd == '0 && $past(mask_rd) == '0) |-> !irq);

   p_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && clr_we) |=>
         ((mask_rd & ~$past(mask_rd)) & $past(clr_data)) == '0);
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
   localparam logic [31:0] IMPL = 32'hC000_1AFB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_we = 1'b0, clr_we = 1'b0;
   logic [31:0] set_data = '0, clr_data = '0, status = '0;
   logic [31:0] mask_rd;
   logic        irq;

   int errors = 0;
   int checks = 0;
   logic [31:0] model = '0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] mask;
      logic        irq;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   irq_mask_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .set_we(set_we), .set_data(set_data),
      .clr_we(clr_we), .clr_data(clr_data),
      .status(status), .mask_rd(mask_rd), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] am, input logic [31:0] em,
                        input logic ai, input logic ei);
      checks++;
      if (am !== em || ai !== ei) begin
         errors++;
         $display("FAIL %s: mask=%h irq=%b expected mask=%h irq=%b", tag, am, ai, em, ei);
      end
   endtask

   // Driver: apply one cycle of stimulus and queue the expected result
   task automatic step(input logic sw, input logic [31:0] sd, input logic cw,
                       input logic [31:0] cd, input logic [31:0] st, input string tag);
      exp_t e;
      @(negedge clk);
      set_we = sw; set_data = sd; clr_we = cw; clr_data = cd; status = st;
      model = (model | (sw ? (sd & IMPL) : 32'h0)) & ~(cw ? cd : 32'h0);
      e.mask = model;
      e.irq  = |(st & model);
      e.tag  = tag;
      sb.push_back(e);
   endtask

   // Monitor: compare after the edge that commits the queued item
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(e.tag, mask_rd, e.mask, irq, e.irq);
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: mask=%h irq=%b expected completion", mask_rd, irq);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      status = '1;
      #23;
      check("R4 reset mask and irq", mask_rd, 32'h0, irq, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      step(1, 32'h0000_0001, 0, 0, 32'h0000_0001, "R1 R7 set rx-ready");
      step(1, 32'hC000_1000, 0, 0, 32'h0000_0000, "R1 R6 set high sources");
      step(1, 32'h0000_0000, 0, 0, 32'h8000_0000, "R3 R7 zero set word");
      step(0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 32'h4000_0000, "R3 no strobe");
      step(0, 0, 1, 32'h0000_0000, 32'h0000_0001, "R3 zero clear word");
      step(0, 0, 1, 32'h0000_0001, 32'h0000_0001, "R2 R9 clear rx-ready");
      step(1, 32'h0000_0004, 0, 0, 32'h0000_0004, "R5 reserved bit 2");
      step(1, 32'hFFFF_FFFF, 0, 0, 32'h0000_0000, "R6 R5 set all");
      step(0, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 clear all");
      step(1, 32'h0000_0260, 1, 32'h0000_0020, 32'h0000_0020, "R8 collision overlap");
      step(1, 32'h0000_0800, 1, 32'h0000_0200, 32'h0000_0A00, "R8 collision disjoint");
      step(1, 32'hFFFF_FFFF, 1, 32'h0000_FFFF, 32'h0000_FFFF, "R8 R9 collision wide");
      step(0, 0, 1, 32'hFFFF_FFFF, 32'h0, "R2 clear all again");
      for (int i = 0; i < 32; i++) begin
         step(1, 32'h1 << i, 0, 0, 32'hFFFF_FFFF, $sformatf("R5 R6 R7 walk set bit %0d", i));
         step(0, 0, 1, 32'h1 << i, 32'hFFFF_FFFF, $sformatf("R2 R9 walk clear bit %0d", i));
      end
      step(0, 0, 0, 0, 0, "R3 idle");
      repeat (3) @(negedge clk);
      // R4: reset in mid-run clears the mask
      step(1, 32'hC000_0003, 0, 0, 32'h0, "R1 preset before reset");
      repeat (2) @(negedge clk);
      set_we = 0; clr_we = 0; status = '1;
      rst_n = 1'b0;
      #1;
      check("R4 async reset clears", mask_rd, 32'h0, irq, 1'b0);
      model = '0;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule